// File: doc/BRIEF.md
# Instruction Fetch Breakpoint Unit

This unit sits beside a simple in-order CPU pipeline and raises a user-break interrupt request when the program reaches a programmed instruction address. It has two independent channels. Each channel holds a break address, an enable, a cycle-type select, a monitored-bus select and a before/after-execution select. Every fetch is compared against both channels, and the result is stored under the fetch's tag. The execute stream later presents that tag. This lets the unit ignore fetches that the pipeline fetched ahead and then threw away on a branch or an interrupt entry.

A channel fires only for an instruction that really executes. A before-execution break is requested when the matching instruction is presented at execute. An after-execution break is requested when the next instruction is presented. A break that lands on the delay slot of a taken delayed branch is held back until the first instruction at the branch target. Each channel has a sticky status flag that software clears by writing 1.

Top module: `ifbrk_unit`

## Requirements
- R1: After reset, brk_req is 0 and both brk_status bits are 0.
- R2: A channel counts as usable only when four things hold: its enable is 1, its cycle-type select is 1 (instruction fetch), its bus select is 0 (primary bus), and bit 0 of its programmed address is 0. If it is usable and cfg_after is 0, then a fetch whose address equals the programmed address, followed by the execute presentation of that fetch's tag (not in a delay slot), drives brk_req to 1 in the cycle after that presentation. The same edge sets the channel's brk_status bit (bit i for channel i).
- R3: With cfg_after at 1, the matching instruction's own presentation requests nothing. brk_req rises in the cycle after the next executed instruction is presented.
- R4: When flush is asserted, every recorded fetch match is dropped, including one from a fetch in the same cycle. A later execute of a flushed tag never fires, even if that tag is reused by a non-matching fetch.
- R5: A channel whose programmed address has bit 0 set to 1 never fires, even when a fetch address equals it exactly.
- R6: A channel with its enable at 0, its cycle-type select at 0 (data access) or its bus select at 1 (secondary bus) never fires.
- R7: The instruction presented right after a taken delayed branch (ex_dbranch=1, ex_taken=1) is its delay slot. No break is requested at the slot's presentation. Two kinds of break are held and fire at the next presented instruction: a break of either mode set on the slot, and an after-execution break set on the branch. A before-execution break on the branch itself fires at the branch's presentation.
- R8: After a delayed branch that is not taken (ex_taken=0), the next instruction is an ordinary instruction, and a before-execution break on it fires at its own presentation.
- R9: When both channels fire on the same presentation, brk_req is high for one cycle only and both brk_status bits are set.
- R10: A brk_status bit stays 1 until stat_clr for that bit is 1. Clearing one bit leaves the other unchanged. A fire in the same cycle as its clear leaves the bit set.
- R11: A fetch match is consumed when its tag is executed. A second execute of the same tag with no new fetch, or an execute of a tag whose fetch did not match, does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | NCH | Per-channel enable |
| cfg_ifetch | input | NCH | Cycle-type select: 1 = instruction fetch, 0 = data access |
| cfg_after | input | NCH | 1 = break after execution, 0 = before execution |
| cfg_sec_bus | input | NCH | 1 = secondary bus selected (channel invalid) |
| cfg_addr | input | NCH*AW | Break addresses, channel i in bits [i*AW +: AW] |
| stat_clr | input | NCH | Write-1-to-clear strobe for brk_status |
| fetch_valid | input | 1 | Fetch strobe |
| fetch_addr | input | AW | Fetch address |
| fetch_tag | input | TW | Tag given to this fetch |
| flush | input | 1 | Discard all fetched-but-unexecuted instructions |
| ex_valid | input | 1 | An instruction is presented at execute |
| ex_tag | input | TW | Tag of the presented instruction |
| ex_dbranch | input | 1 | Presented instruction is a delayed branch |
| ex_taken | input | 1 | The delayed branch is taken |
| brk_req | output | 1 | Single-cycle break request to the CPU |
| brk_status | output | NCH | Sticky per-channel fired flags |

## Verification
The assertions assume an in-order execute stream with a few properties. A delayed branch never sits in a delay slot. Every executed tag was fetched earlier and not reissued before it executes. Configuration is held steady between a fetch and its execution. The bench uses distinct tags within each scenario, never places a branch in a slot, and changes configuration only between scenarios. After every scenario it clears the status flags, so no stale match or status carries into the next one.

// File: rtl/ifbrk_pkg.sv
package ifbrk_pkg;
    localparam int unsigned NCH_DEF = 2;
    localparam int unsigned AW_DEF  = 32;
    localparam int unsigned TW_DEF  = 3;

    typedef struct packed {
        logic en;
        logic ifetch;
        logic sec_bus;
    } chan_gate_t;

    function automatic logic chan_usable(input chan_gate_t g, input logic addr_lsb);
        return g.en && g.ifetch && !g.sec_bus && !addr_lsb;
    endfunction
endpackage

// File: rtl/ifbrk_chan_match.sv
module ifbrk_chan_match
    import ifbrk_pkg::*;
#(
    parameter int unsigned AW = AW_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  chan_gate_t    gate,
    input  logic [AW-1:0] brk_addr,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    output logic          hit
);
    logic usable;

    always_comb begin
        usable = chan_usable(gate, brk_addr[0]);
        hit    = fetch_valid && usable && (fetch_addr == brk_addr);
    end

    // R5: odd break address never produces a hit
    a_r5_odd_addr_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && brk_addr[0]) |-> !hit);

    // R6: disabled, data-type or secondary-bus channel never hits
    a_r6_gated_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate.en || !gate.ifetch || gate.sec_bus) |-> !hit);
endmodule

// File: rtl/ifbrk_tag_table.sv
module ifbrk_tag_table
    import ifbrk_pkg::*;
#(
    parameter int unsigned NCH = NCH_DEF,
    parameter int unsigned TW  = TW_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [TW-1:0]  wr_tag,
    input  logic [NCH-1:0] wr_hit,
    input  logic           flush,
    input  logic           rd_en,
    input  logic [TW-1:0]  rd_tag,
    output logic [NCH-1:0] rd_hit
);
    localparam int unsigned NTAG = 1 << TW;

    logic [NTAG-1:0][NCH-1:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d  = tbl_q;
        rd_hit = rd_en ? tbl_q[rd_tag] : '0;
        if (rd_en) begin
            tbl_d[rd_tag] = '0;
        end
        if (wr_en) begin
            tbl_d[wr_tag] = wr_hit;
        end
        if (flush) begin
            tbl_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // R4: a flush leaves no recorded match behind
    a_r4_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tbl_q == '0));

    // R11: an executed tag's entry is consumed unless refilled the same cycle
    a_r11_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !(wr_en && (wr_tag == rd_tag))) |=> (tbl_q[$past(rd_tag)] == '0));
endmodule

// File: rtl/ifbrk_seq.sv
module ifbrk_seq
    import ifbrk_pkg::*;
#(
    parameter int unsigned NCH = NCH_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ex_valid,
    input  logic           ex_dbranch,
    input  logic           ex_taken,
    input  logic [NCH-1:0] ex_hit,
    input  logic [NCH-1:0] cfg_after,
    input  logic [NCH-1:0] stat_clr,
    output logic           brk_req,
    output logic [NCH-1:0] brk_status
);
    typedef struct packed {
        logic           slot;
        logic [NCH-1:0] pend;
        logic           req;
        logic [NCH-1:0] status;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic [NCH-1:0] pre_hit, post_hit, fire;

    always_comb begin
        s_d      = s_q;
        pre_hit  = ex_hit & ~cfg_after;
        post_hit = ex_hit & cfg_after;
        fire     = '0;
        if (ex_valid) begin
            if (s_q.slot) begin
                s_d.pend = s_q.pend | pre_hit | post_hit;
                s_d.slot = 1'b0;
            end else begin
                fire     = s_q.pend | pre_hit;
                s_d.pend = post_hit;
                s_d.slot = ex_dbranch && ex_taken;
            end
        end
        s_d.req    = |fire;
        s_d.status = (s_q.status & ~stat_clr) | fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign brk_req    = s_q.req;
    assign brk_status = s_q.status;

    // R7: nothing is requested for a delay-slot presentation
    a_r7_hold_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && s_q.slot) |=> !brk_req);

    // R2: a request always follows an execute presentation
    a_r2_req_after_exec: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(ex_valid));

    // R9: every request is accompanied by a set status flag
    a_r9_req_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (brk_status != '0));

    for (genvar i = 0; i < NCH; i++) begin : g_sticky
        // R10: status holds until cleared
        a_r10_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (brk_status[i] && !stat_clr[i]) |=> brk_status[i]);
    end
endmodule

// File: rtl/ifbrk_unit.sv
module ifbrk_unit
    import ifbrk_pkg::*;
#(
    parameter int unsigned NCH = NCH_DEF,
    parameter int unsigned AW  = AW_DEF,
    parameter int unsigned TW  = TW_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    cfg_en,
    input  logic [NCH-1:0]    cfg_ifetch,
    input  logic [NCH-1:0]    cfg_after,
    input  logic [NCH-1:0]    cfg_sec_bus,
    input  logic [NCH*AW-1:0] cfg_addr,
    input  logic [NCH-1:0]    stat_clr,
    input  logic              fetch_valid,
    input  logic [AW-1:0]     fetch_addr,
    input  logic [TW-1:0]     fetch_tag,
    input  logic              flush,
    input  logic              ex_valid,
    input  logic [TW-1:0]     ex_tag,
    input  logic              ex_dbranch,
    input  logic              ex_taken,
    output logic              brk_req,
    output logic [NCH-1:0]    brk_status
);
    logic [NCH-1:0] fetch_hit;
    logic [NCH-1:0] ex_hit;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        chan_gate_t gate;
        assign gate = '{en: cfg_en[i], ifetch: cfg_ifetch[i], sec_bus: cfg_sec_bus[i]};

        ifbrk_chan_match #(.AW(AW)) u_match (
            .clk         (clk),
            .rst_n       (rst_n),
            .gate        (gate),
            .brk_addr    (cfg_addr[i*AW +: AW]),
            .fetch_valid (fetch_valid),
            .fetch_addr  (fetch_addr),
            .hit         (fetch_hit[i])
        );
    end

    ifbrk_tag_table #(.NCH(NCH), .TW(TW)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (fetch_valid),
        .wr_tag (fetch_tag),
        .wr_hit (fetch_hit),
        .flush  (flush),
        .rd_en  (ex_valid),
        .rd_tag (ex_tag),
        .rd_hit (ex_hit)
    );

    ifbrk_seq #(.NCH(NCH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ex_valid   (ex_valid),
        .ex_dbranch (ex_dbranch),
        .ex_taken   (ex_taken),
        .ex_hit     (ex_hit),
        .cfg_after  (cfg_after),
        .stat_clr   (stat_clr),
        .brk_req    (brk_req),
        .brk_status (brk_status)
    );
endmodule

// File: tb/ifbrk_unit_test.sv
module ifbrk_unit_test;
    localparam int NCH = 2;
    localparam int AW  = 32;
    localparam int TW  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0]    cfg_en = '0, cfg_ifetch = '0, cfg_after = '0, cfg_sec_bus = '0;
    logic [NCH*AW-1:0] cfg_addr = '0;
    logic [NCH-1:0]    stat_clr = '0;
    logic              fetch_valid = 1'b0;
    logic [AW-1:0]     fetch_addr = '0;
    logic [TW-1:0]     fetch_tag = '0;
    logic              flush = 1'b0;
    logic              ex_valid = 1'b0;
    logic [TW-1:0]     ex_tag = '0;
    logic              ex_dbranch = 1'b0, ex_taken = 1'b0;
    logic              brk_req;
    logic [NCH-1:0]    brk_status;

    int n_checks = 0;
    int n_fail   = 0;
    logic [NCH-1:0] exp_st = '0;

    ifbrk_unit #(.NCH(NCH), .AW(AW), .TW(TW)) uut (.*);

    always #4 clk = ~clk;

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_ch(input int ch, input bit en, input bit ifc, input bit aft,
                          input bit sec, input logic [AW-1:0] a);
        cfg_en[ch] = en; cfg_ifetch[ch] = ifc; cfg_after[ch] = aft;
        cfg_sec_bus[ch] = sec; cfg_addr[ch*AW +: AW] = a;
    endtask

    task automatic fetch(input logic [AW-1:0] a, input logic [TW-1:0] t);
        fetch_valid = 1'b1; fetch_addr = a; fetch_tag = t;
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic exec(input logic [TW-1:0] t, input bit dbr, input bit tk,
                        input logic [NCH-1:0] mask, input string req);
        ex_valid = 1'b1; ex_tag = t; ex_dbranch = dbr; ex_taken = tk;
        @(negedge clk);
        ex_valid = 1'b0; ex_dbranch = 1'b0; ex_taken = 1'b0;
        exp_st |= mask;
        check(brk_req == (|mask), req, brk_req, |mask);
        check(brk_status == exp_st, req, brk_status, exp_st);
    endtask

    task automatic clr(input logic [NCH-1:0] m, input string req);
        stat_clr = m;
        @(negedge clk);
        stat_clr = '0;
        exp_st &= ~m;
        check(brk_status == exp_st, req, brk_status, exp_st);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(brk_req == 1'b0, "R1", brk_req, 0);
        check(brk_status == '0, "R1", brk_status, 0);

        // R2 R3 R5 R6 R11: sweep over gating bits, mode and channel
        for (int ch = 0; ch < NCH; ch++) begin
            for (int cv = 0; cv < 16; cv++) begin
                for (int aft = 0; aft < 2; aft++) begin
                    logic [AW-1:0] a;
                    logic [TW-1:0] t0, t1;
                    logic [NCH-1:0] m;
                    bit ok;
                    ok = cv[0] && cv[1] && !cv[2] && !cv[3];
                    a  = 32'h0000_1000 + (cv << 4) + (cv[3] ? 1 : 0);
                    t0 = cv[2:0];
                    t1 = t0 + 3'd1;
                    cfg_en = '0;
                    set_ch(ch, cv[0], cv[1], aft[0], cv[2], a);
                    m = ok ? (NCH'(1) << ch) : '0;
                    fetch(a, t0);
                    fetch(a + 32'h100, t1);
                    exec(t0, 0, 0, aft ? '0 : m, aft ? "R3" : (ok ? "R2" : "R6"));
                    exec(t1, 0, 0, aft ? m : '0, aft ? "R3" : "R5");
                    exec(t0, 0, 0, '0, "R11");
                    clr('1, "R10");
                end
            end
        end

        // R4 flush drops match, tag reused by non-matching fetch
        cfg_en = '0;
        set_ch(0, 1, 1, 0, 0, 32'h2000);
        fetch(32'h2000, 3'd5);
        flush = 1'b1; @(negedge clk); flush = 1'b0;
        fetch(32'h2004, 3'd5);
        exec(3'd5, 0, 0, '0, "R4");
        // R4 fetch in the same cycle as flush is also dropped
        fetch_valid = 1'b1; fetch_addr = 32'h2000; fetch_tag = 3'd6; flush = 1'b1;
        @(negedge clk); fetch_valid = 1'b0; flush = 1'b0;
        exec(3'd6, 0, 0, '0, "R4");

        // R7 before-exec break on slot deferred to target
        set_ch(0, 1, 1, 0, 0, 32'h3002);
        fetch(32'h3000, 3'd0); fetch(32'h3002, 3'd1); fetch(32'h4000, 3'd2);
        exec(3'd0, 1, 1, '0, "R7");
        exec(3'd1, 0, 0, '0, "R7");
        exec(3'd2, 0, 0, 2'b01, "R7");
        clr('1, "R10");
        // R7 after-exec on taken branch deferred past slot
        cfg_en = '0;
        set_ch(1, 1, 1, 1, 0, 32'h3000);
        fetch(32'h3000, 3'd0); fetch(32'h3002, 3'd1); fetch(32'h4000, 3'd2);
        exec(3'd0, 1, 1, '0, "R7");
        exec(3'd1, 0, 0, '0, "R7");
        exec(3'd2, 0, 0, 2'b10, "R7");
        clr('1, "R10");
        // R7 after-exec on slot fires at target
        cfg_en = '0;
        set_ch(0, 1, 1, 1, 0, 32'h3002);
        fetch(32'h3000, 3'd0); fetch(32'h3002, 3'd1); fetch(32'h4000, 3'd2);
        exec(3'd0, 1, 1, '0, "R7");
        exec(3'd1, 0, 0, '0, "R7");
        exec(3'd2, 0, 0, 2'b01, "R7");
        clr('1, "R10");
        // R7 before-exec on the branch itself fires at once
        set_ch(0, 1, 1, 0, 0, 32'h3000);
        fetch(32'h3000, 3'd0); fetch(32'h3002, 3'd1); fetch(32'h4000, 3'd2);
        exec(3'd0, 1, 1, 2'b01, "R7");
        exec(3'd1, 0, 0, '0, "R7");
        exec(3'd2, 0, 0, '0, "R7");
        clr('1, "R10");

        // R8 not-taken delayed branch: next is ordinary
        set_ch(0, 1, 1, 0, 0, 32'h3002);
        fetch(32'h3000, 3'd0); fetch(32'h3002, 3'd1);
        exec(3'd0, 1, 0, '0, "R8");
        exec(3'd1, 0, 0, 2'b01, "R8");
        clr('1, "R10");

        // R9 both channels on one instruction: single pulse, both flags
        set_ch(0, 1, 1, 0, 0, 32'h5000);
        set_ch(1, 1, 1, 0, 0, 32'h5000);
        fetch(32'h5000, 3'd3); fetch(32'h5004, 3'd4);
        exec(3'd3, 0, 0, 2'b11, "R9");
        exec(3'd4, 0, 0, '0, "R9");

        // R10 clear one flag only, then set wins over same-cycle clear
        clr(2'b10, "R10");
        cfg_en = 2'b01;
        fetch(32'h5000, 3'd7);
        stat_clr = 2'b01;
        exec(3'd7, 0, 0, 2'b01, "R10");
        stat_clr = '0;
        check(brk_status == 2'b01, "R10", brk_status, 2'b01);
        clr(2'b01, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule